// File: doc/BRIEF.md
# Block Memory Responder with Selectable Bank Organisation

This block sits below a cache and answers whole-block requests of four 32-bit words (16 bytes). A request travels in one bus cycle: a valid strobe, a read/write flag, a byte address and, for writes, the full block of data. The responder then models the storage access latency of the selected memory organisation. A read returns its words on a lane-structured response bus. A write ends with a one-cycle acknowledge.

Three organisations are selectable through a mode input that is sampled when the request is accepted. The sequential organisation has one word-wide bank that is accessed once per word. The wide organisation delivers the whole block from one access. The interleaved organisation has four banks that are accessed together, after which the words are sent one per cycle. Word i of every block lives in bank i and travels on lane i of the response bus.

The control state machine has three states. IDLE leads to ACCESS when a request is accepted. ACCESS stays in ACCESS while the latency count runs and leads to XFER when the count expires. XFER goes back to ACCESS when the sequential organisation still has words to fetch. It stays in XFER when the interleaved organisation still has words to send. It returns to IDLE on the final beat.

Top module: `mem_block_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, req_ready is 1 and rsp_valid, rsp_last, rsp_lanes, rsp_data and wr_ack are all 0.
- R2: req_ready is 1 only in IDLE. A request is accepted in the cycle where req_valid and req_ready are both 1. Requests presented while busy are ignored. req_ready returns in the cycle after the final beat or acknowledge.
- R3: Mode 0 (sequential) and the reserved mode 3 both give four beats. With the address cycle counted as cycle 1, the beats fall in cycles 17, 33, 49 and 65. Beat k drives only lane k (rsp_lanes bit k).
- R4: Mode 1 (wide) gives one beat in cycle 17, with rsp_lanes = 4'b1111 and rsp_last = 1.
- R5: Mode 2 (interleaved) gives four beats in cycles 17, 18, 19 and 20. Beat k drives only lane k.
- R6: rsp_valid is 1 only in beat cycles, and rsp_last only on the final beat. Lane k of rsp_data (bits 32k+31:32k) carries word k of the addressed block while its rsp_lanes bit is set. All other lanes are 0, and all of rsp_data is 0 outside beats.
- R7: A write (req_write = 1) follows the same timing for its mode and never raises rsp_valid. wr_ack pulses for exactly one cycle, in the cycle of the final beat. Word k of req_wdata (bits 32k+31:32k) is stored as word k of the block and can be read back afterwards.
- R8: The block is selected by req_addr[ADDR_W-1:4]. Bits 3:0 have no effect.
- R9: Changing mode, req_addr, req_write or req_wdata while a request is in progress has no effect on that request's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Organisation: 0 sequential, 1 wide, 2 interleaved, 3 as 0 |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_addr | input | ADDR_W | Byte address of the block |
| req_wdata | input | 4*WORD_W | Write block, word k in lane k |
| req_ready | output | 1 | Responder idle, request can be taken |
| rsp_valid | output | 1 | Read data beat |
| rsp_last | output | 1 | Final read beat |
| rsp_lanes | output | 4 | Lanes carrying data in this beat |
| rsp_data | output | 4*WORD_W | Read data, word k in lane k |
| wr_ack | output | 1 | Write complete pulse |

## Verification
The bench builds the block with its default parameters: a 15-cycle access latency, 32-bit words and a 10-bit address giving 64 blocks. These values make the cycle counts 65, 17 and 20 directly comparable with a behavioural timing model. The blocks are far enough apart that nonzero offset bits and distinct block indices can be exercised. The same latency reaches every beat position of every organisation. Holding requests and toggling the mode during busy periods exercises the ignore rules.

// File: rtl/mem_resp_pkg.sv
package mem_resp_pkg;

    typedef enum logic [1:0] {
        ORG_SEQ  = 2'd0,
        ORG_WIDE = 2'd1,
        ORG_ILV  = 2'd2,
        ORG_RSV  = 2'd3
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_XFER
    } st_e;

endpackage

// File: rtl/mem_resp_bank.sv
module mem_resp_bank #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/mem_resp_ctrl.sv
module mem_resp_ctrl
    import mem_resp_pkg::*;
#(
    parameter int BLK_WORDS = 4,
    parameter int ACC_LAT   = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic                 req_valid,
    output logic                 req_ready,
    output logic                 beat_en,
    output logic                 beat_last,
    output logic [BLK_WORDS-1:0] beat_lanes
);

    localparam int CNT_W  = $clog2(ACC_LAT + 1);
    localparam int WSEL_W = $clog2(BLK_WORDS);

    st_e               st;
    org_e              org_q;
    logic [CNT_W-1:0]  cnt;
    logic [WSEL_W-1:0] widx;
    logic              final_word;

    assign final_word = (widx == WSEL_W'(BLK_WORDS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            org_q <= ORG_SEQ;
            cnt   <= '0;
            widx  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        st    <= ST_ACCESS;
                        cnt   <= CNT_W'(ACC_LAT - 1);
                        widx  <= '0;
                        org_q <= (org_e'(mode) == ORG_RSV) ? ORG_SEQ : org_e'(mode);
                    end
                end
                ST_ACCESS: begin
                    if (cnt == '0) begin
                        st <= ST_XFER;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_XFER: begin
                    if (org_q == ORG_WIDE || final_word) begin
                        st <= ST_IDLE;
                    end else if (org_q == ORG_SEQ) begin
                        st   <= ST_ACCESS;
                        cnt  <= CNT_W'(ACC_LAT - 1);
                        widx <= widx + WSEL_W'(1);
                    end else begin
                        widx <= widx + WSEL_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (st == ST_IDLE);
        beat_en    = (st == ST_XFER);
        beat_last  = 1'b0;
        beat_lanes = '0;
        if (st == ST_XFER) begin
            if (org_q == ORG_WIDE) begin
                beat_lanes = '1;
                beat_last  = 1'b1;
            end else begin
                beat_lanes[widx] = 1'b1;
                beat_last        = final_word;
            end
        end
    end

    assert_last_in_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_en);

    assert_seq_refetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_en && org_q == ORG_SEQ && !beat_last) |=> (st == ST_ACCESS && cnt == CNT_W'(ACC_LAT - 1)));

    assert_wide_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_en && org_q == ORG_WIDE) |-> (beat_last && $countones(beat_lanes) == BLK_WORDS));

    assert_ilv_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_en && org_q == ORG_ILV && !beat_last) |=> beat_en);

    assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(org_q));

endmodule

// File: rtl/mem_block_responder.sv
module mem_block_responder #(
    parameter int ADDR_W    = 10,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int ACC_LAT   = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  mode,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [BLK_WORDS*WORD_W-1:0] req_wdata,
    output logic                        req_ready,
    output logic                        rsp_valid,
    output logic                        rsp_last,
    output logic [BLK_WORDS-1:0]        rsp_lanes,
    output logic [BLK_WORDS*WORD_W-1:0] rsp_data,
    output logic                        wr_ack
);

    localparam int OFF_W = $clog2(BLK_WORDS * WORD_W / 8);
    localparam int IDX_W = ADDR_W - OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    logic                        accept;
    logic                        beat_en;
    logic                        beat_last;
    logic [BLK_WORDS-1:0]        beat_lanes;
    logic [IDX_W-1:0]            idx_q;
    logic                        wr_q;
    logic [BLK_WORDS*WORD_W-1:0] wdata_q;
    logic                        unused_offset;

    assign unused_offset = ^req_addr[OFF_W-1:0];
    assign accept        = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            idx_q   <= req_addr[ADDR_W-1:OFF_W];
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    mem_resp_ctrl #(
        .BLK_WORDS (BLK_WORDS),
        .ACC_LAT   (ACC_LAT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .beat_en    (beat_en),
        .beat_last  (beat_last),
        .beat_lanes (beat_lanes)
    );

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_bank
        logic [WORD_W-1:0] rd;
        mem_resp_bank #(
            .WORD_W (WORD_W),
            .DEPTH  (DEPTH)
        ) u_bank (
            .clk   (clk),
            .we    (beat_en && wr_q && beat_lanes[g]),
            .addr  (idx_q),
            .wdata (wdata_q[g*WORD_W +: WORD_W]),
            .rdata (rd)
        );
        assign rsp_data[g*WORD_W +: WORD_W] =
            (beat_en && !wr_q && beat_lanes[g]) ? rd : '0;
    end

    assign rsp_valid = beat_en && !wr_q;
    assign rsp_last  = beat_last && !wr_q;
    assign rsp_lanes = rsp_valid ? beat_lanes : '0;
    assign wr_ack    = beat_last && wr_q;

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || wr_ack) |-> !req_ready);

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> (!wr_ack && req_ready));

    assert_ack_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (!rsp_valid && rsp_lanes == '0));

endmodule

// File: tb/mem_block_responder_test.sv
`timescale 1ns/1ps
module mem_block_responder_test;

    localparam int L = 15;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [9:0]   req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic         rsp_last;
    logic [3:0]   rsp_lanes;
    logic [127:0] rsp_data;
    logic         wr_ack;

    always #4 clk = ~clk;

    mem_block_responder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .rsp_lanes (rsp_lanes),
        .rsp_data  (rsp_data),
        .wr_ack    (wr_ack)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural model
    logic [31:0]  mm [64][4];
    bit           m_busy = 0;
    int           m_t = 0;
    int           m_org = 0;
    int           m_idx = 0;
    bit           m_wr = 0;
    logic [127:0] m_wd = '0;

    function automatic int n_of(int org);
        if (org == 1) return L + 2;
        if (org == 2) return L + 1 + W;
        return 1 + W * (L + 1);
    endfunction

    task automatic check(bit ok, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit hit = 0;
        bit lst = 0;
        logic [3:0] ln = '0;
        logic [127:0] dat = '0;
        bit ev;
        bit ea;
        if (m_busy) begin
            if (m_org == 1) begin
                if (m_t == L + 2) begin hit = 1; lst = 1; ln = 4'hF; end
            end else if (m_org == 2) begin
                if (m_t >= L + 2 && m_t <= L + 1 + W) begin
                    hit = 1; ln[m_t - L - 2] = 1'b1; lst = (m_t == L + 1 + W);
                end
            end else begin
                if (m_t >= L + 2 && ((m_t - 1) % (L + 1)) == 0) begin
                    hit = 1; ln[(m_t - 1) / (L + 1) - 1] = 1'b1; lst = (m_t == n_of(0));
                end
            end
        end
        ev = hit && !m_wr;
        ea = hit && lst && m_wr;
        if (!ev) ln = '0;
        for (int k = 0; k < 4; k++) if (ln[k]) dat[k*32 +: 32] = mm[m_idx][k];
        check(req_ready == !m_busy, "req_ready", 128'(req_ready), 128'(!m_busy));
        check(rsp_valid == ev, "rsp_valid", 128'(rsp_valid), 128'(ev));
        check(rsp_last == (ev && lst), "rsp_last", 128'(rsp_last), 128'(ev && lst));
        check(rsp_lanes == ln, "rsp_lanes", 128'(rsp_lanes), 128'(ln));
        check(rsp_data == dat, "rsp_data(R6)", rsp_data, dat);
        check(wr_ack == ea, "wr_ack", 128'(wr_ack), 128'(ea));
    endtask

    task automatic step(bit v, bit w, logic [9:0] a, logic [127:0] d, logic [1:0] md);
        bit acc;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; mode = md;
        acc = !m_busy && v && rst_n;
        @(posedge clk);
        if (m_busy) begin
            if (m_t == n_of(m_org)) begin
                m_busy = 0;
                if (m_wr) for (int k = 0; k < 4; k++) mm[m_idx][k] = m_wd[k*32 +: 32];
            end else begin
                m_t++;
            end
        end else if (acc) begin
            m_busy = 1; m_t = 2;
            m_org = (md == 2'd3) ? 0 : int'(md);
            m_idx = int'(a[9:4]); m_wr = w; m_wd = d;
        end
        @(negedge clk);
        compare();
    endtask

    // hold: keep a foreign request on the bus while busy; tog: flip mode while busy
    task automatic run(string t, bit w, logic [9:0] a, logic [127:0] d, logic [1:0] md, bit hold, bit tog);
        tag = t;
        step(1'b1, w, a, d, md);
        while (m_busy) begin
            step(hold, !w, a ^ 10'h3F5, ~d, tog ? (md ^ 2'b11) : md);
        end
    endtask

    function automatic logic [127:0] blk(logic [31:0] s);
        return {s + 32'd3, s + 32'd2, s + 32'd1, s};
    endfunction

    initial begin
        #(8 * 20000);
        bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0, '0, 2'd0);
        step(1'b0, 1'b0, '0, '0, 2'd0);

        // R7: writes in every organisation, R8 with offset bits set
        run("R7", 1'b1, {6'd5, 4'h0}, blk(32'hA5000010), 2'd0, 1'b0, 1'b0);
        run("R8", 1'b1, {6'd9, 4'h7}, blk(32'h99000020), 2'd1, 1'b0, 1'b0);
        run("R7", 1'b1, {6'd12, 4'h0}, blk(32'hC1200030), 2'd2, 1'b0, 1'b0);

        // reads in each organisation
        run("R3", 1'b0, {6'd5, 4'h0}, '0, 2'd0, 1'b0, 1'b0);
        run("R4", 1'b0, {6'd5, 4'h0}, '0, 2'd1, 1'b0, 1'b0);
        run("R5", 1'b0, {6'd5, 4'h0}, '0, 2'd2, 1'b0, 1'b0);
        run("R3", 1'b0, {6'd9, 4'hC}, '0, 2'd3, 1'b0, 1'b0);
        run("R8", 1'b0, {6'd12, 4'hD}, '0, 2'd2, 1'b0, 1'b0);

        // R2: foreign requests held during busy, back-to-back acceptance
        run("R2", 1'b0, {6'd12, 4'h0}, '0, 2'd2, 1'b1, 1'b0);
        run("R2", 1'b0, {6'd9, 4'h0}, '0, 2'd1, 1'b1, 1'b0);

        // R9: mode and request fields changing mid-transaction
        run("R9", 1'b0, {6'd12, 4'h0}, '0, 2'd0, 1'b1, 1'b1);
        run("R9", 1'b1, {6'd5, 4'h0}, blk(32'h5E000040), 2'd2, 1'b1, 1'b1);
        run("R6", 1'b0, {6'd5, 4'h0}, '0, 2'd1, 1'b0, 1'b0);
        run("R6", 1'b0, {6'd5, 4'h0}, '0, 2'd0, 1'b0, 1'b1);

        tag = "R2";
        step(1'b0, 1'b0, '0, '0, 2'd0);
        step(1'b0, 1'b0, '0, '0, 2'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule